// File: doc/BRIEF.md
# Segmented Gamma Table Register Port

This block holds one pipe's gamma lookup table and gives software register access to it. The table has three parts. A short superfine section covers the darkest codes. A fine section and a coarse section follow and together cover the rest of the range. Each colour channel's value at full scale sits in its own register. Each table entry carries three 16-bit channel values: red, green and blue. Software moves an entry as two 32-bit words through a data register. The first word holds the six least significant bits of every channel. The second word holds the ten most significant bits.

There are two independent pointer/data pairs. One reaches the superfine section. The other reaches the fine section and then the coarse section as a single continuous stream. Software writes a pointer word, which can set an auto-advance flag. It then reads or writes word pairs through the matching data register. The pointer advances once per completed pair and stops at the last entry of its section. The bus side is a plain strobe interface: one cycle per access, byte addressed, with read data registered.

Top module: `gamma_lut_regs`

## Requirements
- R1: After reset both pointers are 0 with auto-advance off, every maximum register reads 0, and `reg_rdata` is 0.
- R2: Byte offsets are 0x00 superfine pointer, 0x04 superfine data, 0x08 main pointer, 0x0C main data, 0x10/0x14/0x18 red/green/blue maximum. Read data appears on `reg_rdata` one cycle after `reg_rd` and holds until the next read. Any other offset reads 0.
- R3: A pointer word holds the entry number in its low bits (4 bits superfine, 9 bits main) and the auto-advance flag in bit 31. It reads back in the same layout, with all other bits 0. A number past the section's last entry is clamped to the last entry.
- R4: For a write pair, the first word gives the low six bits of red at 29:24, green at 19:14 and blue at 9:4. The second word gives the high ten bits of red at 29:20, green at 19:10 and blue at 9:0. The stored value is high10 shifted left by 6, ORed with low6. The entry is stored only when the second word arrives.
- R5: A read pair returns the stored entry in the same two-word format, with every bit outside those fields 0.
- R6: With auto-advance set, the pointer moves up by one after the second word of a pair, whether the pair is a read or a write. It never moves after a first word. With the flag clear, the pointer does not move.
- R7: Auto-advance stops at the last entry (8 superfine, 511 main). Further pairs then act on that last entry.
- R8: Main entries 0 to 255 are the fine knots and 256 to 511 are the coarse knots. One auto-advancing stream crosses from fine into coarse without a break.
- R9: Accesses through one pointer/data pair leave the other pair's pointer, flag and word position unchanged.
- R10: Writing a pointer word in the middle of a pair drops the half-finished pair. The next data access is then taken as a first word.
- R11: Each maximum register keeps bits 15:0 of the written word. Bits 31:16 are ignored and read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Single-cycle write strobe |
| reg_rd | input | 1 | Single-cycle read strobe |
| reg_addr | input | ADDR_W | Byte offset of the access |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Registered read data |

## Verification
The assertions assume that `reg_wr` and `reg_rd` are never high in the same cycle, because the pair position is shared between reads and writes. They also assume that a data read never targets an entry that has not been written since reset. The directed bench issues one strobe per access, with an idle low cycle between accesses. It writes every entry before it reads it back. The bench drives only the listed offsets, except in the test that deliberately reads unmapped offsets.

// File: rtl/gamma_lut_pkg.sv
package gamma_lut_pkg;
   localparam int NCH    = 3;
   localparam int CH_W   = 16;
   localparam int LO_W   = 6;
   localparam int HI_W   = CH_W - LO_W;
   localparam int SLOT_W = 10;
   localparam int AUTO_BIT = 31;

   localparam int OFS_SF_IDX = 'h00;
   localparam int OFS_SF_DAT = 'h04;
   localparam int OFS_MN_IDX = 'h08;
   localparam int OFS_MN_DAT = 'h0C;
   localparam int OFS_MAX0   = 'h10;
   localparam int MAX_STRIDE = 4;

   // channel 2 = red, 1 = green, 0 = blue
   typedef logic [NCH-1:0][CH_W-1:0] entry_t;

   function automatic logic [31:0] lo_word(entry_t e);
      logic [31:0] w;
      w = '0;
      for (int c = 0; c < NCH; c++)
         w[c*SLOT_W + SLOT_W - LO_W +: LO_W] = e[c][LO_W-1:0];
      return w;
   endfunction

   function automatic logic [31:0] hi_word(entry_t e);
      logic [31:0] w;
      w = '0;
      for (int c = 0; c < NCH; c++)
         w[c*SLOT_W +: HI_W] = e[c][CH_W-1 -: HI_W];
      return w;
   endfunction

   function automatic entry_t merge(logic [31:0] lo, logic [31:0] hi);
      entry_t e;
      for (int c = 0; c < NCH; c++)
         e[c] = {hi[c*SLOT_W +: HI_W], lo[c*SLOT_W + SLOT_W - LO_W +: LO_W]};
      return e;
   endfunction
endpackage

// File: rtl/gamma_seg_port.sv
module gamma_seg_port
   import gamma_lut_pkg::*;
#(
   parameter int DEPTH = 9,
   parameter int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             idx_we,
   input  logic             dat_we,
   input  logic             dat_re,
   input  logic [31:0]      wdata,
   output logic [31:0]      idx_word,
   output logic [31:0]      dat_word,
   output logic [IDX_W-1:0] idx_q,
   output logic             phase_q,
   output logic             auto_q
);
   localparam logic [IDX_W-1:0] LAST = IDX_W'(DEPTH - 1);

   if (NCH * SLOT_W > 30) begin : g_bad_slots
      $error("channel slots do not fit in a data word");
   end
   if (SLOT_W < HI_W || SLOT_W < LO_W) begin : g_bad_slot_w
      $error("slot narrower than a field");
   end
   if (IDX_W >= AUTO_BIT) begin : g_bad_idx
      $error("index field overlaps the auto-advance flag");
   end

   entry_t      mem [DEPTH];
   logic [31:0] lo_hold;
   logic [IDX_W-1:0] idx_in;
   logic        access;
   logic        unused_bits;

   assign unused_bits = ^{wdata[31:30], lo_hold};
   assign access = dat_we | dat_re;
   assign idx_in = (wdata[IDX_W-1:0] > LAST) ? LAST : wdata[IDX_W-1:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         idx_q   <= '0;
         phase_q <= 1'b0;
         auto_q  <= 1'b0;
         lo_hold <= '0;
      end else if (idx_we) begin
         idx_q   <= idx_in;
         auto_q  <= wdata[AUTO_BIT];
         phase_q <= 1'b0;
      end else if (access) begin
         phase_q <= ~phase_q;
         if (!phase_q && dat_we)
            lo_hold <= wdata;
         if (phase_q && auto_q && idx_q < LAST)
            idx_q <= idx_q + 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (!idx_we && dat_we && phase_q)
         mem[idx_q] <= merge(lo_hold, wdata);
   end

   always_comb begin
      idx_word = '0;
      idx_word[AUTO_BIT] = auto_q;
      idx_word[IDX_W-1:0] = idx_q;
      dat_word = phase_q ? hi_word(mem[idx_q]) : lo_word(mem[idx_q]);
   end
endmodule

// File: rtl/gamma_max_regs.sv
module gamma_max_regs
   import gamma_lut_pkg::*;
#(
   parameter int N = NCH
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic [N-1:0]            we,
   input  logic [CH_W-1:0]         wdata,
   output logic [N-1:0][CH_W-1:0]  max_q
);
   for (genvar c = 0; c < N; c++) begin : g_ch
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            max_q[c] <= '0;
         else if (we[c])
            max_q[c] <= wdata;
      end
   end
endmodule

// File: rtl/gamma_lut_regs.sv
module gamma_lut_regs
   import gamma_lut_pkg::*;
#(
   parameter int SF_DEPTH     = 9,
   parameter int FINE_DEPTH   = 256,
   parameter int COARSE_DEPTH = 256,
   parameter int ADDR_W       = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic              reg_rd,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [31:0]       reg_wdata,
   output logic [31:0]       reg_rdata
);
   localparam int MN_DEPTH = FINE_DEPTH + COARSE_DEPTH;
   localparam int SF_IDX_W = (SF_DEPTH > 1) ? $clog2(SF_DEPTH) : 1;
   localparam int MN_IDX_W = $clog2(MN_DEPTH);
   localparam int TOP_OFS  = OFS_MAX0 + NCH * MAX_STRIDE;

   if (TOP_OFS > (1 << ADDR_W)) begin : g_bad_addr
      $error("address width too small for the register map");
   end
   if (FINE_DEPTH < 1 || COARSE_DEPTH < 1 || SF_DEPTH < 1) begin : g_bad_depth
      $error("every segment needs at least one entry");
   end

   logic sel_sf_idx, sel_sf_dat, sel_mn_idx, sel_mn_dat;
   logic [NCH-1:0] sel_max;

   assign sel_sf_idx = reg_addr == ADDR_W'(OFS_SF_IDX);
   assign sel_sf_dat = reg_addr == ADDR_W'(OFS_SF_DAT);
   assign sel_mn_idx = reg_addr == ADDR_W'(OFS_MN_IDX);
   assign sel_mn_dat = reg_addr == ADDR_W'(OFS_MN_DAT);
   for (genvar c = 0; c < NCH; c++) begin : g_sel
      // red at the lowest maximum offset
      assign sel_max[c] = reg_addr == ADDR_W'(OFS_MAX0 + (NCH - 1 - c) * MAX_STRIDE);
   end

   logic sf_iwe, sf_dwe, sf_dre, mn_iwe, mn_dwe, mn_dre;
   assign sf_iwe = reg_wr & sel_sf_idx;
   assign sf_dwe = reg_wr & sel_sf_dat;
   assign sf_dre = reg_rd & sel_sf_dat;
   assign mn_iwe = reg_wr & sel_mn_idx;
   assign mn_dwe = reg_wr & sel_mn_dat;
   assign mn_dre = reg_rd & sel_mn_dat;

   logic [31:0] sf_idx_word, sf_dat_word, mn_idx_word, mn_dat_word;
   logic [SF_IDX_W-1:0] sf_idx;
   logic [MN_IDX_W-1:0] mn_idx;
   logic sf_phase, sf_auto, mn_phase, mn_auto;

   gamma_seg_port #(.DEPTH(SF_DEPTH), .IDX_W(SF_IDX_W)) u_sf (
      .clk(clk), .rst_n(rst_n),
      .idx_we(sf_iwe), .dat_we(sf_dwe), .dat_re(sf_dre), .wdata(reg_wdata),
      .idx_word(sf_idx_word), .dat_word(sf_dat_word),
      .idx_q(sf_idx), .phase_q(sf_phase), .auto_q(sf_auto)
   );

   gamma_seg_port #(.DEPTH(MN_DEPTH), .IDX_W(MN_IDX_W)) u_mn (
      .clk(clk), .rst_n(rst_n),
      .idx_we(mn_iwe), .dat_we(mn_dwe), .dat_re(mn_dre), .wdata(reg_wdata),
      .idx_word(mn_idx_word), .dat_word(mn_dat_word),
      .idx_q(mn_idx), .phase_q(mn_phase), .auto_q(mn_auto)
   );

   logic [NCH-1:0][CH_W-1:0] max_q;
   logic unused_wdata;
   assign unused_wdata = ^reg_wdata[31:CH_W];

   gamma_max_regs #(.N(NCH)) u_max (
      .clk(clk), .rst_n(rst_n),
      .we({NCH{reg_wr}} & sel_max),
      .wdata(reg_wdata[CH_W-1:0]),
      .max_q(max_q)
   );

   logic [31:0] rd_mux;
   always_comb begin
      rd_mux = '0;
      if (sel_sf_idx) rd_mux = sf_idx_word;
      if (sel_sf_dat) rd_mux = sf_dat_word;
      if (sel_mn_idx) rd_mux = mn_idx_word;
      if (sel_mn_dat) rd_mux = mn_dat_word;
      for (int c = 0; c < NCH; c++)
         if (sel_max[c]) rd_mux = 32'(max_q[c]);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         reg_rdata <= '0;
      else if (reg_rd)
         reg_rdata <= rd_mux;
   end
endmodule

// File: rtl/gamma_lut_regs_chk.sv
module gamma_lut_regs_chk #(
   parameter int SF_IDX_W = 4,
   parameter int MN_IDX_W = 9,
   parameter int SF_LAST  = 8,
   parameter int MN_LAST  = 511
) (
   input logic                clk,
   input logic                rst_n,
   input logic                reg_rd,
   input logic [31:0]         reg_rdata,
   input logic                sf_iwe,
   input logic                sf_acc,
   input logic [SF_IDX_W-1:0] sf_idx,
   input logic                sf_phase,
   input logic                sf_auto,
   input logic                mn_iwe,
   input logic                mn_acc,
   input logic [MN_IDX_W-1:0] mn_idx,
   input logic                mn_phase
);
   // R2
   rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !reg_rd |=> $stable(reg_rdata));

   // R10
   idx_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sf_iwe || mn_iwe) |=> (!sf_phase || !$past(sf_iwe)) && (!mn_phase || !$past(mn_iwe)));

   // R6
   sf_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sf_acc && !sf_iwe && sf_phase && sf_auto && sf_idx < SF_IDX_W'(SF_LAST))
      |=> sf_idx == $past(sf_idx) + 1'b1);

   // R6
   mn_first_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mn_acc && !mn_iwe && !mn_phase) |=> $stable(mn_idx) && mn_phase);

   // R7
   mn_saturate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mn_acc && !mn_iwe && mn_idx == MN_IDX_W'(MN_LAST)) |=> mn_idx == MN_IDX_W'(MN_LAST));

   // R9
   sf_isolation_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!sf_iwe && !sf_acc) |=> $stable(sf_idx) && $stable(sf_phase) && $stable(sf_auto));

   // R9
   mn_isolation_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!mn_iwe && !mn_acc) |=> $stable(mn_idx) && $stable(mn_phase));
endmodule

bind gamma_lut_regs gamma_lut_regs_chk #(
   .SF_IDX_W(SF_IDX_W), .MN_IDX_W(MN_IDX_W),
   .SF_LAST(SF_DEPTH - 1), .MN_LAST(MN_DEPTH - 1)
) u_chk (
   .clk(clk), .rst_n(rst_n), .reg_rd(reg_rd), .reg_rdata(reg_rdata),
   .sf_iwe(sf_iwe), .sf_acc(sf_dwe | sf_dre), .sf_idx(sf_idx),
   .sf_phase(sf_phase), .sf_auto(sf_auto),
   .mn_iwe(mn_iwe), .mn_acc(mn_dwe | mn_dre), .mn_idx(mn_idx),
   .mn_phase(mn_phase)
);

// File: tb/gamma_lut_regs_bench.sv
`timescale 1ns/1ps
module gamma_lut_regs_bench;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic reg_wr = 1'b0;
   logic reg_rd = 1'b0;
   logic [7:0] reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;

   int n_run = 0;
   int n_fail = 0;
   bit done = 1'b0;

   localparam logic [7:0] A_SFI = 8'h00, A_SFD = 8'h04, A_MNI = 8'h08,
                          A_MND = 8'h0C, A_MR = 8'h10, A_MG = 8'h14, A_MB = 8'h18;
   localparam logic [31:0] AUTO = 32'h8000_0000;

   always #2.5 clk = ~clk;

   gamma_lut_regs u_gamma_lut_regs (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
      .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
   );

   function automatic logic [47:0] gen(int k);
      logic [15:0] r, g, b;
      r = 16'(k * 16'h03A7 + 16'h1111);
      g = 16'(k * 16'h0C53) ^ 16'hA5A5;
      b = 16'hFFFF - 16'(k * 16'h0101);
      return {r, g, b};
   endfunction

   // first word: low six bits at 29:24, 19:14, 9:4
   function automatic logic [31:0] lo_of(logic [47:0] e);
      return {2'b00, e[37:32], 4'h0, e[21:16], 4'h0, e[5:0], 4'h0};
   endfunction

   // second word: high ten bits at 29:20, 19:10, 9:0
   function automatic logic [31:0] hi_of(logic [47:0] e);
      return {2'b00, e[47:38], e[31:22], e[15:6]};
   endfunction

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: got %h expected %h", req, act, exp);
      end
   endtask

   task automatic wr(logic [7:0] a, logic [31:0] d);
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rd(logic [7:0] a, output logic [31:0] d);
      @(negedge clk);
      reg_rd = 1'b1; reg_addr = a;
      @(negedge clk);
      reg_rd = 1'b0;
      d = reg_rdata;
   endtask

   task automatic wr_entry(logic [7:0] a, logic [47:0] e);
      wr(a, lo_of(e));
      wr(a, hi_of(e));
   endtask

   task automatic chk_entry(string req, logic [7:0] a, logic [47:0] e);
      logic [31:0] d;
      rd(a, d); chk(req, d, lo_of(e));
      rd(a, d); chk(req, d, hi_of(e));
   endtask

   task automatic t_reset();
      logic [31:0] d;
      chk("R1 rdata", reg_rdata, 32'h0);
      rd(A_SFI, d); chk("R1 sf pointer", d, 32'h0);
      rd(A_MNI, d); chk("R1 main pointer", d, 32'h0);
      rd(A_MR, d);  chk("R1 max red", d, 32'h0);
      rd(A_MB, d);  chk("R1 max blue", d, 32'h0);
   endtask

   task automatic t_sf_fill();
      logic [31:0] d;
      wr(A_SFI, AUTO);
      for (int k = 0; k < 9; k++) wr_entry(A_SFD, gen(k));
      rd(A_SFI, d); chk("R7 sf stops at 8", d, AUTO | 32'd8);
      wr(A_SFI, AUTO);
      for (int k = 0; k < 9; k++) chk_entry("R4 R5 sf entry", A_SFD, gen(k));
   endtask

   task automatic t_main_cross();
      logic [31:0] d;
      wr(A_MNI, AUTO | 32'd254);
      for (int k = 0; k < 4; k++) wr_entry(A_MND, gen(100 + k));
      rd(A_MNI, d); chk("R8 pointer past fine/coarse edge", d, AUTO | 32'd258);
      wr(A_MNI, AUTO | 32'd254);
      for (int k = 0; k < 4; k++) chk_entry("R8 entry across edge", A_MND, gen(100 + k));
   endtask

   task automatic t_saturate();
      logic [31:0] d;
      wr(A_MNI, AUTO | 32'd510);
      for (int k = 0; k < 3; k++) wr_entry(A_MND, gen(200 + k));
      rd(A_MNI, d); chk("R7 main stops at 511", d, AUTO | 32'd511);
      wr(A_MNI, AUTO | 32'd510);
      chk_entry("R7 entry 510", A_MND, gen(200));
      chk_entry("R7 entry 511 last write", A_MND, gen(202));
   endtask

   task automatic t_no_auto();
      logic [31:0] d;
      wr(A_MNI, 32'd5);
      wr_entry(A_MND, gen(300));
      rd(A_MNI, d); chk("R6 no advance without flag", d, 32'd5);
      wr_entry(A_MND, gen(301));
      chk_entry("R6 overwrite in place", A_MND, gen(301));
      rd(A_MNI, d); chk("R6 read pair no advance", d, 32'd5);
   endtask

   task automatic t_mid_pair();
      logic [31:0] d;
      wr(A_MNI, AUTO | 32'd20);
      wr(A_MND, lo_of(gen(400)));
      rd(A_MNI, d); chk("R6 no advance after first word", d, AUTO | 32'd20);
      wr(A_MNI, AUTO | 32'd20);
      wr_entry(A_MND, gen(401));
      rd(A_MNI, d); chk("R10 restarted pair advances once", d, AUTO | 32'd21);
      wr(A_MNI, 32'd20);
      chk_entry("R10 restarted entry", A_MND, gen(401));
   endtask

   task automatic t_isolation();
      logic [31:0] d;
      wr(A_MNI, AUTO | 32'd40);
      wr(A_MND, lo_of(gen(500)));
      wr(A_SFI, AUTO | 32'd3);
      wr_entry(A_SFD, gen(501));
      wr(A_MND, hi_of(gen(500)));
      rd(A_MNI, d); chk("R9 main pointer", d, AUTO | 32'd41);
      rd(A_SFI, d); chk("R9 sf pointer", d, AUTO | 32'd4);
      wr(A_MNI, 32'd40);
      chk_entry("R9 main entry", A_MND, gen(500));
      wr(A_SFI, 32'd3);
      chk_entry("R9 sf entry", A_SFD, gen(501));
   endtask

   task automatic t_clamp();
      logic [31:0] d;
      wr(A_SFI, 32'h7FFF_FFFF);
      rd(A_SFI, d); chk("R3 clamp and zero bits", d, 32'd8);
      wr(A_MNI, 32'hFFFF_FE07);
      rd(A_MNI, d); chk("R3 main pointer layout", d, AUTO | 32'h07);
   endtask

   task automatic t_max();
      logic [31:0] d;
      wr(A_MR, 32'hABCD_1234);
      wr(A_MG, 32'h0000_BEEF);
      wr(A_MB, 32'hFFFF_0001);
      rd(A_MR, d); chk("R11 max red", d, 32'h1234);
      rd(A_MG, d); chk("R11 max green", d, 32'hBEEF);
      rd(A_MB, d); chk("R11 max blue", d, 32'h0001);
   endtask

   task automatic t_unmapped();
      logic [31:0] d;
      rd(8'h1C, d); chk("R2 unmapped 0x1C", d, 32'h0);
      rd(8'h40, d); chk("R2 unmapped 0x40", d, 32'h0);
      rd(A_MG, d);
      repeat (3) @(negedge clk);
      chk("R2 rdata held", reg_rdata, 32'hBEEF);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_sf_fill();
      t_main_cross();
      t_saturate();
      t_no_auto();
      t_mid_pair();
      t_isolation();
      t_clamp();
      t_max();
      t_unmapped();
      if (!done) begin
         done = 1'b1;
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         n_run++;
         n_fail++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end
endmodule